// File: doc/BRIEF.md
# Shared-Bus Address Splitter and Cycle Decoder

This block sits beside an 8-bit processor whose low address byte and data byte travel on the same eight wires. A strobe from the processor marks the window in which those wires carry the address. The block keeps that byte and joins it with the dedicated high address byte, so peripherals see one stable 16-bit address for the whole cycle.

The block also classifies every bus cycle. A space-select input chooses between the 16-bit memory space and the separate 8-bit port space. Two active-low strobes carry read and write. From these, the block raises exactly one of memory read, memory write, port read and port write. When both strobes are low at once, it flags a clash instead. A small parameterised table of memory addresses and port numbers turns matching cycles into chip selects. Memory entries are compared against the full 16-bit address. Port entries are compared against the low byte only.

Top module: `shared_bus_decoder`

## Requirements
- R1: While `addr_strobe` is high, `addr[7:0]` follows `shared_bus` in the same cycle, and `addr[15:8]` always equals `hi_addr`.
- R2: While `addr_strobe` is low, `addr[7:0]` holds the `shared_bus` value sampled at the last rising clock edge at which `addr_strobe` was high. Changes on `shared_bus` in that time have no effect on `addr`.
- R3: When `port_space`=0, `rd_n`=0 and `wr_n`=1, only `mem_rd` is high among the five cycle outputs.
- R4: When `port_space`=0, `wr_n`=0 and `rd_n`=1, only `mem_wr` is high.
- R5: When `port_space`=1, a low `rd_n` alone raises only `io_rd`, and a low `wr_n` alone raises only `io_wr`.
- R6: When `rd_n` and `wr_n` are both 0, `bus_err` is high, the four cycle outputs are low, and every chip select is low.
- R7: When `rd_n` and `wr_n` are both 1, all cycle outputs and all chip selects are low.
- R8: `mem_cs[i]` is high exactly during a memory read or write whose `addr` equals table entry i. By default, entry 0 is 8000h and entry 1 is 8001h.
- R9: `port_cs[j]` is high exactly during a port read or write whose `addr[7:0]` equals port entry j, whatever `hi_addr` is. By default, entry 0 is 01h and entry 1 is 02h.
- R10: No bit of `mem_cs` is ever high in the same cycle as any bit of `port_cs`.
- R11: After a synchronous reset, with `addr_strobe` low, `addr[7:0]` reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | High while the shared lines carry the low address |
| hi_addr | input | 8 | Dedicated high address byte |
| shared_bus | input | 8 | Shared low-address/data lines |
| port_space | input | 1 | 1 selects the port space, 0 selects the memory space |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | output | 16 | Joined 16-bit address |
| mem_rd | output | 1 | Memory read cycle |
| mem_wr | output | 1 | Memory write cycle |
| io_rd | output | 1 | Port read cycle |
| io_wr | output | 1 | Port write cycle |
| bus_err | output | 1 | Read and write asserted together |
| mem_cs | output | 2 | Memory-mapped chip selects |
| port_cs | output | 2 | Port-mapped chip selects |

## Verification
The bench drives full bus cycles where the shared lines switch from address to an unrelated data byte once the strobe drops. A design that latched on the wrong edge, or stayed transparent, would then select the wrong peripheral.

Port cycles are run with the high byte set to values that alias a memory entry. A decoder that compared all 16 bits, or that ignored the space select, would fire the wrong select or both kinds at once.

Both strobes are pulled low together on a matching address, which would expose a design that still drives a chip select during a clash. Long runs of random cycles compare every output against a behavioural model on every clock.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_MEM_RD,
        CYC_MEM_WR,
        CYC_IO_RD,
        CYC_IO_WR,
        CYC_CLASH
    } cyc_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic clash;
    } strobes_s;

    function automatic cyc_e classify(input logic port_space, input logic rd_n, input logic wr_n);
        cyc_e c;
        if (!rd_n && !wr_n)      c = CYC_CLASH;
        else if (!rd_n)          c = port_space ? CYC_IO_RD : CYC_MEM_RD;
        else if (!wr_n)          c = port_space ? CYC_IO_WR : CYC_MEM_WR;
        else                     c = CYC_IDLE;
        return c;
    endfunction

    function automatic strobes_s expand(input cyc_e c);
        strobes_s s;
        s        = '0;
        s.mem_rd = (c == CYC_MEM_RD);
        s.mem_wr = (c == CYC_MEM_WR);
        s.io_rd  = (c == CYC_IO_RD);
        s.io_wr  = (c == CYC_IO_WR);
        s.clash  = (c == CYC_CLASH);
        return s;
    endfunction

endpackage

// File: rtl/sbd_addr_latch.sv
module sbd_addr_latch #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8,
    localparam int ADDR_W = DATA_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_strobe,
    input  logic [HI_W-1:0]   hi_addr,
    input  logic [DATA_W-1:0] shared_bus,
    output logic [ADDR_W-1:0] addr
);

    logic [DATA_W-1:0] held_q;
    logic [DATA_W-1:0] lo_byte;

    always_ff @(posedge clk) begin
        if (rst)              held_q <= '0;
        else if (addr_strobe) held_q <= shared_bus;
    end

    // transparent while the strobe is high, frozen once it drops
    always_comb lo_byte = addr_strobe ? shared_bus : held_q;
    assign addr = {hi_addr, lo_byte};

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_strobe) && $past(!rst) |-> lo_byte == $past(shared_bus));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !addr_strobe && $past(!addr_strobe) |-> $stable(lo_byte));

endmodule

// File: rtl/sbd_cycle_decode.sv
module sbd_cycle_decode
    import sbd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     port_space,
    input  logic     rd_n,
    input  logic     wr_n,
    output cyc_e     cyc,
    output strobes_s strobes
);

    always_comb begin
        cyc     = classify(port_space, rd_n, wr_n);
        strobes = expand(cyc);
    end

    p_one_kind_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes));

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        rd_n && wr_n |-> strobes == '0);

    p_space_r5: assert property (@(posedge clk) disable iff (rst)
        port_space |-> !strobes.mem_rd && !strobes.mem_wr);

endmodule

// File: rtl/sbd_select_gen.sv
module sbd_select_gen
    import sbd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8,
    parameter int N_MEM  = 2,
    parameter int N_PORT = 2,
    parameter logic [N_MEM*ADDR_W-1:0]  MEM_MAP  = 32'h8001_8000,
    parameter logic [N_PORT*PORT_W-1:0] PORT_MAP = 16'h0201
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_e              cyc,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_MEM-1:0]  mem_cs,
    output logic [N_PORT-1:0] port_cs
);

    logic mem_cycle;
    logic port_cycle;

    always_comb begin
        mem_cycle  = (cyc == CYC_MEM_RD) || (cyc == CYC_MEM_WR);
        port_cycle = (cyc == CYC_IO_RD)  || (cyc == CYC_IO_WR);
    end

    for (genvar i = 0; i < N_MEM; i++) begin : g_mem
        assign mem_cs[i] = mem_cycle && (addr == MEM_MAP[i*ADDR_W +: ADDR_W]);
    end

    for (genvar j = 0; j < N_PORT; j++) begin : g_port
        assign port_cs[j] = port_cycle && (addr[PORT_W-1:0] == PORT_MAP[j*PORT_W +: PORT_W]);
    end

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !((|mem_cs) && (|port_cs)));

    p_clash_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        cyc == CYC_CLASH |-> mem_cs == '0 && port_cs == '0);

endmodule

// File: rtl/shared_bus_decoder.sv
module shared_bus_decoder
    import sbd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int N_MEM  = 2,
    parameter int N_PORT = 2,
    parameter logic [N_MEM*ADDR_W-1:0]  MEM_MAP  = 32'h8001_8000,
    parameter logic [N_PORT*DATA_W-1:0] PORT_MAP = 16'h0201
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    addr_strobe,
    input  logic [ADDR_W-DATA_W-1:0] hi_addr,
    input  logic [DATA_W-1:0]       shared_bus,
    input  logic                    port_space,
    input  logic                    rd_n,
    input  logic                    wr_n,
    output logic [ADDR_W-1:0]       addr,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic                    io_rd,
    output logic                    io_wr,
    output logic                    bus_err,
    output logic [N_MEM-1:0]        mem_cs,
    output logic [N_PORT-1:0]       port_cs
);

    localparam int HI_W = ADDR_W - DATA_W;

    cyc_e     cyc;
    strobes_s strobes;

    sbd_addr_latch #(.DATA_W(DATA_W), .HI_W(HI_W)) u_latch (
        .clk(clk), .rst(rst), .addr_strobe(addr_strobe),
        .hi_addr(hi_addr), .shared_bus(shared_bus), .addr(addr)
    );

    sbd_cycle_decode u_decode (
        .clk(clk), .rst(rst), .port_space(port_space),
        .rd_n(rd_n), .wr_n(wr_n), .cyc(cyc), .strobes(strobes)
    );

    sbd_select_gen #(
        .ADDR_W(ADDR_W), .PORT_W(DATA_W), .N_MEM(N_MEM), .N_PORT(N_PORT),
        .MEM_MAP(MEM_MAP), .PORT_MAP(PORT_MAP)
    ) u_select (
        .clk(clk), .rst(rst), .cyc(cyc), .addr(addr),
        .mem_cs(mem_cs), .port_cs(port_cs)
    );

    assign mem_rd  = strobes.mem_rd;
    assign mem_wr  = strobes.mem_wr;
    assign io_rd   = strobes.io_rd;
    assign io_wr   = strobes.io_wr;
    assign bus_err = strobes.clash;

    p_memcs_needs_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        |mem_cs |-> (mem_rd || mem_wr));

    p_portcs_needs_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        |port_cs |-> (io_rd || io_wr));

endmodule

// File: tb/test_shared_bus_decoder.sv
module test_shared_bus_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_strobe = 1'b0;
    logic [7:0]  hi_addr = '0;
    logic [7:0]  shared_bus = '0;
    logic        port_space = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] addr;
    logic        mem_rd, mem_wr, io_rd, io_wr, bus_err;
    logic [1:0]  mem_cs, port_cs;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] ref_held = '0;

    always #2 clk = ~clk;

    shared_bus_decoder i_shared_bus_decoder (
        .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .hi_addr(hi_addr),
        .shared_bus(shared_bus), .port_space(port_space), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .bus_err(bus_err), .mem_cs(mem_cs), .port_cs(port_cs)
    );

    // reference latch state, updated from the requirements at each rising edge
    always @(posedge clk) begin
        if (rst)              ref_held <= 8'h00;
        else if (addr_strobe) ref_held <= shared_bus;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0]  lo;
        logic [15:0] a;
        logic rd, wr, e_mrd, e_mwr, e_ird, e_iwr, e_err;
        logic [1:0] e_mcs, e_pcs;
        lo = addr_strobe ? shared_bus : ref_held;
        a  = {hi_addr, lo};
        rd = !rd_n;
        wr = !wr_n;
        e_err = rd && wr;
        e_mrd = !port_space && rd && !wr;
        e_mwr = !port_space && wr && !rd;
        e_ird = port_space && rd && !wr;
        e_iwr = port_space && wr && !rd;
        e_mcs[0] = (e_mrd || e_mwr) && a == 16'h8000;
        e_mcs[1] = (e_mrd || e_mwr) && a == 16'h8001;
        e_pcs[0] = (e_ird || e_iwr) && lo == 8'h01;
        e_pcs[1] = (e_ird || e_iwr) && lo == 8'h02;
        chk(addr_strobe ? "R1 addr" : "R2 addr", 32'(addr), 32'(a));
        if (e_err)                chk("R6 cycle", 32'({mem_rd, mem_wr, io_rd, io_wr, bus_err}), 32'(5'b00001));
        else if (!rd && !wr)      chk("R7 cycle", 32'({mem_rd, mem_wr, io_rd, io_wr, bus_err}), 32'(5'b00000));
        else if (e_mrd)           chk("R3 cycle", 32'({mem_rd, mem_wr, io_rd, io_wr, bus_err}), 32'(5'b10000));
        else if (e_mwr)           chk("R4 cycle", 32'({mem_rd, mem_wr, io_rd, io_wr, bus_err}), 32'(5'b01000));
        else                      chk("R5 cycle", 32'({mem_rd, mem_wr, io_rd, io_wr, bus_err}),
                                      32'({1'b0, 1'b0, e_ird, e_iwr, 1'b0}));
        chk("R8 mem_cs", 32'(mem_cs), 32'(e_mcs));
        chk("R9 port_cs", 32'(port_cs), 32'(e_pcs));
        chk("R10 exclusive", 32'((|mem_cs) && (|port_cs)), 32'(0));
    endtask

    // drive at the falling edge, compare 1 ns later, before the rising edge
    task automatic step(input logic s, input logic [7:0] hi, input logic [7:0] bus,
                        input logic ps, input logic r_n, input logic w_n);
        @(negedge clk);
        addr_strobe = s; hi_addr = hi; shared_bus = bus;
        port_space = ps; rd_n = r_n; wr_n = w_n;
        #1 compare();
    endtask

    // one full bus cycle: address phase, then data phase with new data on the lines
    task automatic bus_cycle(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dat,
                             input logic ps, input logic r_n, input logic w_n);
        step(1'b1, hi, lo, ps, 1'b1, 1'b1);
        step(1'b0, hi, dat, ps, r_n, w_n);
        step(1'b0, hi, ~dat, ps, r_n, w_n);
        step(1'b0, hi, dat, ps, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R11 reset low byte", 32'(addr[7:0]), 32'h00);
        @(negedge clk);
        rst = 1'b0;
        #1 compare();
        bus_cycle(8'h80, 8'h00, 8'h5A, 1'b0, 1'b0, 1'b1); // R3 read, R8 entry 0
        bus_cycle(8'h80, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0); // R4 write, R8 entry 1, data aliases 8000h
        bus_cycle(8'h80, 8'h02, 8'h01, 1'b0, 1'b0, 1'b1); // R8 no match
        bus_cycle(8'hFF, 8'h01, 8'h02, 1'b1, 1'b0, 1'b1); // R5 port read, R9 high byte ignored
        bus_cycle(8'h80, 8'h02, 8'h01, 1'b1, 1'b1, 1'b0); // R5 port write, R10 with aliasing high byte
        bus_cycle(8'h80, 8'h00, 8'h33, 1'b0, 1'b0, 1'b0); // R6 clash on matching address
        bus_cycle(8'h00, 8'h01, 8'h44, 1'b1, 1'b0, 1'b0); // R6 clash on matching port
        bus_cycle(8'h12, 8'h34, 8'h56, 1'b0, 1'b1, 1'b1); // R7 idle, R2 hold
        for (int k = 0; k < 400; k++) begin
            logic [7:0] hi, bus;
            hi  = ($urandom % 4 == 0) ? 8'h80 : 8'($urandom);
            bus = ($urandom % 3 == 0) ? 8'($urandom % 3) : 8'($urandom);
            step(1'($urandom), hi, bus, 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule